// File: doc/BRIEF.md
# Banked Pin Configuration Register Block

This block holds the configuration of a group of general-purpose pins and turns it into pad controls. Each pin owns a single byte-wide register address in a window that starts at a base offset (0x150 by default). Behind that one address sit six four-bit configuration banks. The upper bits of each written byte select a bank. Bit 7 decides whether the write also stores the low nibble into that bank, or only moves the pin's bank pointer so that a later read returns that bank.

The stored fields drive each pad. Mode, level and open-drain come from one bank. Tristate and output strength come from another. Inversion comes from a third, and function select from a fourth. The block computes output enable and the driven level, and returns the pad input level corrected for inversion. Voltage-source select, enable flag, bias code, strength and function select are exported as plain fields for neighbouring analog and muxing logic.

Top module: `gpio_bank_cfg`

## Requirements
- R1: After reset every bank of every pin reads 0, every bank pointer is 0 and no pad output enable is asserted.
- R2: A write to address BASE_ADDR+p with bit 7 set stores bits 3:0 into bank bits 6:4 (banks 0 to 5) of pin p and also points that pin at the bank.
- R3: A write with bit 7 clear changes no stored configuration and no pad output; it only sets the pin's bank pointer to bits 6:4.
- R4: A read strobe to a pin address places {4'b0, selected bank} on host_rdata one clock later, and host_rdata holds until the next read. Bank pointers 6 and 7, and addresses outside the pin window, read 0. Writes to such banks or addresses store nothing.
- R5: Each pin keeps its own bank pointer.
- R6: Bank 1 bits 3:2 hold the mode (0 input, 1 both, 2 output, 3 off) and bit 0 the output level. Bank 3 bits 3:2 hold strength (0 none). pad_oe is set only for mode 1 or 2 with nonzero strength and tristate clear.
- R7: Bank 1 bit 1 set selects open drain: pad_out is 0, and pad_oe is dropped while the driven level is 1.
- R8: Bank 5 bit 3 clear inverts the pin: the driven level is the stored level inverted, and pin_level is pad_in inverted. Bit 3 set passes both through.
- R9: Bank 3 bit 0 set forces pad_oe low for that pin.
- R10: Bank 0 bits 3:1 are exported as voltage select and bit 0 as enable. Bank 2 bits 3:1 are exported as bias code and bank 4 bits 3:1 as function select. Bank 3 bits 3:2 are exported as strength.
- R11: A read and a write to the same pin in one cycle return the bank pointer and contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_addr | input | ADDR_W | Register address |
| host_wdata | input | 8 | Write byte: commit flag, bank, field nibble |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_rdata | output | 8 | Registered read data |
| pad_in | input | NUM_PINS | Sampled pad levels |
| pad_oe | output | NUM_PINS | Pad output enables |
| pad_out | output | NUM_PINS | Pad driven levels |
| pin_level | output | NUM_PINS | Input levels after inversion |
| vsrc_sel | output | 3*NUM_PINS | Voltage source select per pin |
| pin_enable | output | NUM_PINS | Enable flag per pin |
| bias_code | output | 3*NUM_PINS | Bias code per pin |
| drive_str | output | 2*NUM_PINS | Output strength per pin |
| func_sel | output | 3*NUM_PINS | Function select per pin |

## Verification
A bank read and a bank update can land on the same pin in one clock. This happens when the host raises both strokes at one address, so that a committing write changes both the pointer and the bank while the read samples them. The bench provokes this on a pin whose pointer already names a bank with known contents. It expects the read to return those old contents, and a second read to show the new nibble.

// File: rtl/gpio_bank_cfg.sv
module gpio_bank_cfg #(
  parameter int NUM_PINS  = 8,
  parameter int ADDR_W    = 10,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 10'h150
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     host_addr,
  input  logic [7:0]            host_wdata,
  input  logic                  host_wr,
  input  logic                  host_rd,
  output logic [7:0]            host_rdata,
  input  logic [NUM_PINS-1:0]   pad_in,
  output logic [NUM_PINS-1:0]   pad_oe,
  output logic [NUM_PINS-1:0]   pad_out,
  output logic [NUM_PINS-1:0]   pin_level,
  output logic [3*NUM_PINS-1:0] vsrc_sel,
  output logic [NUM_PINS-1:0]   pin_enable,
  output logic [3*NUM_PINS-1:0] bias_code,
  output logic [2*NUM_PINS-1:0] drive_str,
  output logic [3*NUM_PINS-1:0] func_sel
);
  localparam int IDX_W  = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
  localparam int NBANKS = 6;

  logic [3:0] cfg [NUM_PINS][8];
  logic [2:0] ptr [NUM_PINS];

  logic [ADDR_W-1:0] offs;
  logic [IDX_W-1:0]  sel;
  logic              hit;
  logic [2:0]        wbank;
  logic [2:0]        rbank;

  assign offs  = host_addr - BASE_ADDR;
  assign sel   = offs[IDX_W-1:0];
  assign hit   = (host_addr >= BASE_ADDR) && (offs < ADDR_W'(NUM_PINS));
  assign wbank = host_wdata[6:4];
  assign rbank = ptr[sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NUM_PINS; p++) begin
        ptr[p] <= '0;
        for (int b = 0; b < 8; b++) cfg[p][b] <= '0;
      end
      host_rdata <= '0;
    end else begin
      if (host_wr && hit) begin
        ptr[sel] <= wbank;
        if (host_wdata[7] && (int'(wbank) < NBANKS))
          cfg[sel][wbank] <= host_wdata[3:0];
      end
      if (host_rd)
        host_rdata <= (hit && (int'(rbank) < NBANKS)) ? {4'b0, cfg[sel][rbank]} : 8'h00;
    end
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    logic [1:0] mode;
    logic       od, lvl, dis, inv, drive, lvl_eff;

    assign mode    = cfg[g][1][3:2];
    assign od      = cfg[g][1][1];
    assign lvl     = cfg[g][1][0];
    assign dis     = cfg[g][3][0];
    assign inv     = ~cfg[g][5][3];
    assign drive   = (mode == 2'd1 || mode == 2'd2) && !dis && (cfg[g][3][3:2] != 2'd0);
    assign lvl_eff = lvl ^ inv;

    assign pad_oe[g]    = drive && (!od || !lvl_eff);
    assign pad_out[g]   = drive && !od && lvl_eff;
    assign pin_level[g] = pad_in[g] ^ inv;

    assign vsrc_sel[3*g +: 3]  = cfg[g][0][3:1];
    assign pin_enable[g]       = cfg[g][0][0];
    assign bias_code[3*g +: 3] = cfg[g][2][3:1];
    assign drive_str[2*g +: 2] = cfg[g][3][3:2];
    assign func_sel[3*g +: 3]  = cfg[g][4][3:1];

    a_r9_tristate_wins: assert property (@(posedge clk) disable iff (!rst_n)
      cfg[g][3][0] |-> !pad_oe[g]);
    a_r7_od_never_high: assert property (@(posedge clk) disable iff (!rst_n)
      cfg[g][1][1] |-> !pad_out[g]);
    a_r6_off_mode_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg[g][1][3:2] == 2'd3 || cfg[g][1][3:2] == 2'd0) |-> !pad_oe[g]);
  end

  a_r3_select_only: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !host_wdata[7]) |=> ($stable(pad_oe) && $stable(pad_out)));
  a_r4_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |=> $stable(host_rdata));
  a_r4_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !hit) |=> (host_rdata == 8'h00));
endmodule

// File: tb/test_gpio_bank_cfg.sv
module test_gpio_bank_cfg;
  localparam int N = 8;
  localparam int AW = 10;
  localparam logic [AW-1:0] BASE = 10'h150;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic host_wr = 0, host_rd = 0;
  logic [7:0] host_rdata;
  logic [N-1:0] pad_in = '0, pad_oe, pad_out, pin_level, pin_enable;
  logic [3*N-1:0] vsrc_sel, bias_code, func_sel;
  logic [2*N-1:0] drive_str;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  gpio_bank_cfg #(.NUM_PINS(N), .ADDR_W(AW), .BASE_ADDR(BASE)) i_gpio_bank_cfg (
    .clk, .rst_n, .host_addr, .host_wdata, .host_wr, .host_rd, .host_rdata,
    .pad_in, .pad_oe, .pad_out, .pin_level, .vsrc_sel, .pin_enable,
    .bias_code, .drive_str, .func_sel);

  // {pin, bank, nibble}
  localparam logic [11:0] VEC [6] = '{
    12'h0_0_5, 12'h1_1_A, 12'h2_2_8, 12'h0_3_D, 12'h1_4_6, 12'h2_5_F};

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(int pin, logic [7:0] d);
    @(negedge clk);
    host_addr = BASE + AW'(pin); host_wdata = d; host_wr = 1;
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic rd_addr(logic [AW-1:0] a, output logic [7:0] q);
    @(negedge clk);
    host_addr = a; host_rd = 1;
    @(negedge clk);
    host_rd = 0; q = host_rdata;
  endtask

  task automatic rd_bank(int pin, int bank, output logic [7:0] q);
    wr(pin, {1'b0, 3'(bank), 4'hF});
    rd_addr(BASE + AW'(pin), q);
  endtask

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] q;
    repeat (3) @(negedge clk);
    rst_n = 1;

    rd_addr(BASE, q);
    chk("R1 reset bank0", q, 0);
    chk("R1 reset oe", pad_oe, 0);
    rd_bank(5, 3, q);
    chk("R1 reset bank3", q, 0);

    for (int i = 0; i < 6; i++)
      wr(int'(VEC[i][11:8]), {1'b1, VEC[i][6:4], VEC[i][3:0]});
    for (int i = 0; i < 6; i++) begin
      rd_bank(int'(VEC[i][11:8]), int'(VEC[i][7:4]), q);
      chk("R2 bank readback", q, {4'h0, VEC[i][3:0]});
    end

    wr(0, 8'h3F);
    rd_addr(BASE, q);
    chk("R3 select-only keeps bank3", q, 8'h0D);

    wr(1, 8'h10);
    wr(2, 8'h50);
    rd_addr(BASE + 1, q);
    chk("R5 pin1 own pointer", q, 8'h0A);
    rd_addr(BASE + 2, q);
    chk("R5 pin2 own pointer", q, 8'h0F);

    wr(0, 8'hE7);
    rd_bank(0, 6, q);
    chk("R4 bank6 reads zero", q, 0);
    rd_addr(BASE + N, q);
    chk("R4 above window zero", q, 0);
    @(negedge clk);
    host_addr = BASE - 1; host_wdata = 8'hBF; host_wr = 1;
    @(negedge clk);
    host_wr = 0;
    rd_bank(0, 3, q);
    chk("R4 below window ignored", q, 8'h0D);

    // pin 4 decode, bank5 bit3 set = not inverted
    wr(4, 8'hD8);
    wr(4, 8'h99);
    chk("R6 strength none no oe", pad_oe[4], 0);
    wr(4, 8'hB4);
    chk("R6 output oe", pad_oe[4], 1);
    chk("R6 output level", pad_out[4], 1);
    wr(4, 8'h94);
    chk("R6 both mode oe", pad_oe[4], 1);
    chk("R6 both mode level low", pad_out[4], 0);
    wr(4, 8'h9D);
    chk("R6 off mode no oe", pad_oe[4], 0);
    wr(4, 8'h99);
    wr(4, 8'hB5);
    chk("R9 tristate", pad_oe[4], 0);
    wr(4, 8'hB4);
    wr(4, 8'hD0);
    chk("R8 inverted level", pad_out[4], 0);
    pad_in[4] = 1; #1;
    chk("R8 inverted input", pin_level[4], 0);
    wr(4, 8'hD8);
    chk("R8 plain input", pin_level[4], 1);
    wr(4, 8'h9B);
    chk("R7 od level1 released", pad_oe[4], 0);
    wr(4, 8'h9A);
    chk("R7 od level0 oe", pad_oe[4], 1);
    chk("R7 od drives low", pad_out[4], 0);

    wr(6, 8'hCA);
    wr(6, 8'h8D);
    wr(6, 8'hA9);
    wr(6, 8'hB8);
    chk("R10 func", func_sel[18 +: 3], 5);
    chk("R10 vsrc", vsrc_sel[18 +: 3], 6);
    chk("R10 enable", pin_enable[6], 1);
    chk("R10 bias", bias_code[18 +: 3], 4);
    chk("R10 strength", drive_str[12 +: 2], 2);

    wr(7, 8'hA3);
    @(negedge clk);
    host_addr = BASE + 7; host_wdata = 8'hA6; host_wr = 1; host_rd = 1;
    @(negedge clk);
    host_wr = 0; host_rd = 0;
    chk("R11 same-cycle old value", host_rdata, 8'h03);
    rd_addr(BASE + 7, q);
    chk("R11 new value after", q, 8'h06);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule